// File: doc/BRIEF.md
# Cache Tag Directory with Hit Detection

This block is the directory half of a cache. It keeps one tag word and one valid flag for each cache set, addressed by a set index. A processor-side controller uses it in three ways. It can write a tag into a set, which also marks the set valid. It can read back the tag stored in a set. It can look up a set: the stored tag is compared with the tag presented on the input, and a hit flag reports whether the line is held in the cache.

Access control follows the usual static-memory pattern. A select input enables the device. A write-enable input chooses between storing and looking up. An output-enable input gates the returned tag. All results are registered and appear one clock after the request.

Several directories can share one hit line in a wired-AND fashion. To support that, the hit flag comes with a separate drive-enable, which is high only in cycles where this device answers a lookup. A synchronous reset invalidates the whole directory by walking through every set, one per clock. A busy flag is raised while the walk runs. The depth is 2^IDX_W sets of TAG_W-bit tags: the default is 1024 sets, and IDX_W = 13 with TAG_W = 8 gives the full 8K x 8 directory.

Top module: `tag_directory`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is sampled high, `busy` is 1 and `hit`, `hit_en`, `tag_out_en` and `tag_out` are all 0.
- R2: After `rst` is released, `busy` stays high for exactly 2^IDX_W rising edges and then falls.
- R3: When the invalidation walk ends, a lookup of any set with any tag gives `hit` = 0, and the returned tag is 0.
- R4: A request with `sel`=1 and `wen`=1 while not busy stores `tag_in` at set `idx` and marks that set valid. In the following cycle `hit`, `hit_en` and `tag_out_en` are 0.
- R5: A request with `sel`=1 and `wen`=0 while not busy is a lookup. One clock later `hit_en` is 1, and `hit` is 1 only when the set is valid and all TAG_W bits of the stored tag equal `tag_in`.
- R6: One clock after a lookup that has `oen`=1, `tag_out_en` is 1 and `tag_out` carries the stored tag of that set. In every other cycle `tag_out_en` is 0 and `tag_out` is 0.
- R7: With `sel`=0, nothing is stored. In the next cycle `hit_en` and `tag_out_en` are 0.
- R8: While `busy` is high, writes and lookups are ignored: nothing is stored, and `hit_en` and `tag_out_en` stay 0.
- R9: A second reset after tags have been written invalidates every set again, so later lookups of the previously written tags miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; starts the invalidation walk |
| sel | input | 1 | Device select, active high |
| wen | input | 1 | 1 = store tag, 0 = look up |
| oen | input | 1 | Output enable for the returned tag |
| idx | input | IDX_W | Set index |
| tag_in | input | TAG_W | Tag to store or to compare |
| tag_out | output | TAG_W | Stored tag of the looked-up set, 0 when not driven |
| tag_out_en | output | 1 | `tag_out` carries valid data |
| hit | output | 1 | Lookup found a valid, equal tag |
| hit_en | output | 1 | This device drives the shared hit line this cycle |
| busy | output | 1 | Invalidation walk in progress |

## Verification
The risky overlap is between the invalidation walk and a processor request that lands in the same cycle. Both want the single write port, and the walk must win. To provoke this, the bench issues a write or a lookup on every cycle of the walk, alternating between the two. The result is judged in two ways: `hit_en` and `tag_out_en` must stay low during the walk, and a full sweep afterwards must find no set valid. A second overlap is a write followed at once by a lookup of the same set. Every such pair is checked against the bench's own model of the stored tags.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  // Request class decoded from the access controls.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOOK  = 2'd2
  } tagdir_op_e;

  function automatic tagdir_op_e decode_op(input logic sel, input logic wen,
                                           input logic busy);
    if (busy || !sel) return OP_IDLE;
    return wen ? OP_STORE : OP_LOOK;
  endfunction

endpackage

// File: rtl/tagdir_array.sv
module tagdir_array #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tagdir_sweep.sv
module tagdir_sweep #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          look,
  input  logic          oe,
  input  logic [TW-1:0] tag_in,
  input  logic          ent_valid,
  input  logic [TW-1:0] ent_tag,
  output logic          hit,
  output logic          hit_en,
  output logic [TW-1:0] rd_tag,
  output logic          rd_en
);
  logic          look_q;
  logic          oe_q;
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      look_q <= 1'b0;
      oe_q   <= 1'b0;
      tag_q  <= '0;
    end else begin
      look_q <= look;
      oe_q   <= oe;
      tag_q  <= tag_in;
    end
  end

  // Entry words come from the synchronous array read, aligned with the stage.
  always_comb begin
    hit_en = look_q;
    hit    = look_q && ent_valid && (ent_tag == tag_q);
    rd_en  = look_q && oe_q;
    rd_tag = rd_en ? ent_tag : '0;
  end
endmodule

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wen,
  input  logic             oen,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_out,
  output logic             tag_out_en,
  output logic             hit,
  output logic             hit_en,
  output logic             busy
);
  import tagdir_pkg::*;

  localparam int EW = TAG_W + 1;  // valid flag above the tag

  tagdir_op_e       op;
  logic [IDX_W-1:0] walk_addr;
  logic             walking;
  logic             arr_we;
  logic [IDX_W-1:0] arr_waddr;
  logic [EW-1:0]    arr_wdata;
  logic [EW-1:0]    arr_rdata;

  tagdir_sweep #(.AW(IDX_W)) u_sweep (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .addr (walk_addr)
  );

  always_comb begin
    walking   = rst || busy;
    op        = decode_op(sel, wen, walking);
    arr_we    = walking || (op == OP_STORE);
    arr_waddr = walking ? walk_addr : idx;
    arr_wdata = walking ? '0 : {1'b1, tag_in};
  end

  tagdir_array #(.AW(IDX_W), .DW(EW)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (idx),
    .rdata (arr_rdata)
  );

  tagdir_match #(.TW(TAG_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .look      (op == OP_LOOK),
    .oe        (oen),
    .tag_in    (tag_in),
    .ent_valid (arr_rdata[TAG_W]),
    .ent_tag   (arr_rdata[TAG_W-1:0]),
    .hit       (hit),
    .hit_en    (hit_en),
    .rd_tag    (tag_out),
    .rd_en     (tag_out_en)
  );
endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sel,
  input logic             wen,
  input logic             busy,
  input logic             hit,
  input logic             hit_en,
  input logic             tag_out_en,
  input logic [TAG_W-1:0] tag_out
);
  localparam int          CW   = IDX_W + 2;
  localparam logic [CW-1:0] SPAN = CW'(1) << IDX_W;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (busy && !hit && !hit_en && !tag_out_en));

  p_walk_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == SPAN);

  p_store_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (sel && wen && !busy) |=> (!hit && !hit_en && !tag_out_en));

  p_hit_owned_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_en);

  p_answer_src_r5: assert property (@(posedge clk) disable iff (rst)
    hit_en |-> $past(sel && !wen && !busy));

  p_tag_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !tag_out_en |-> tag_out == '0);

  p_unsel_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!hit_en && !tag_out_en));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!hit_en && !tag_out_en));
endmodule

bind tag_directory tagdir_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel        (sel),
  .wen        (wen),
  .busy       (busy),
  .hit        (hit),
  .hit_en     (hit_en),
  .tag_out_en (tag_out_en),
  .tag_out    (tag_out)
);

// File: tb/sim_tag_directory.sv
module sim_tag_directory;
  localparam int IW = 4;
  localparam int TW = 4;
  localparam int N  = 1 << IW;
  localparam int T  = 1 << TW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          wen = 1'b0;
  logic          oen = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [TW-1:0] tag_in = '0;
  logic [TW-1:0] tag_out;
  logic          tag_out_en;
  logic          hit;
  logic          hit_en;
  logic          busy;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  ref_tag [N];
  bit  ref_val [N];

  always #10 clk = ~clk;

  tag_directory #(.IDX_W(IW), .TAG_W(TW)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wen(wen), .oen(oen), .idx(idx),
    .tag_in(tag_in), .tag_out(tag_out), .tag_out_en(tag_out_en),
    .hit(hit), .hit_en(hit_en), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic o,
                      input int i, input int t);
    @(negedge clk);
    sel = s; wen = w; oen = o; idx = i[IW-1:0]; tag_in = t[TW-1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic wait_walk(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
      chk("R8 hit_en during walk", int'(hit_en), 0);
      chk("R8 tag_out_en during walk", int'(tag_out_en), 0);
      @(negedge clk);
      wen = ~wen; idx = idx + 1'b1;
    end while (busy && cyc < 200);
    sel = 1'b0;
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < N; i++) begin ref_tag[i] = 0; ref_val[i] = 1'b0; end

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", int'(busy), 1);
    chk("R1 hit", int'(hit), 0);
    chk("R1 hit_en", int'(hit_en), 0);
    chk("R1 tag_out_en", int'(tag_out_en), 0);
    chk("R1 tag_out", int'(tag_out), 0);

    // R2 / R8: release reset with requests arriving during the walk
    @(negedge clk);
    rst = 1'b0; sel = 1'b1; wen = 1'b1; oen = 1'b1; idx = 3; tag_in = 5;
    wait_walk(cyc);
    chk("R2 walk length", cyc, N);

    // R3 / R8: every set invalid, nothing stored during the walk
    for (int i = 0; i < N; i++)
      for (int t = 0; t < T; t++) begin
        step(1'b1, 1'b0, 1'b1, i, t);
        chk("R3 hit", int'(hit), 0);
        chk("R3 hit_en", int'(hit_en), 1);
        chk("R3 tag_out_en", int'(tag_out_en), 1);
        chk("R3 tag_out", int'(tag_out), 0);
      end

    // R4: store tags into even sets
    for (int i = 0; i < N; i += 2) begin
      step(1'b1, 1'b1, 1'b1, i, (i * 5 + 3) % T);
      ref_tag[i] = (i * 5 + 3) % T; ref_val[i] = 1'b1;
      chk("R4 hit", int'(hit), 0);
      chk("R4 hit_en", int'(hit_en), 0);
      chk("R4 tag_out_en", int'(tag_out_en), 0);
      chk("R4 tag_out", int'(tag_out), 0);
    end

    // R4: store then immediately look up the same set
    step(1'b1, 1'b1, 1'b0, 1, 11);
    ref_tag[1] = 11; ref_val[1] = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1, 11);
    chk("R4 back-to-back hit", int'(hit), 1);
    chk("R4 back-to-back tag", int'(tag_out), 11);

    // R5 / R6: exhaustive lookup sweep, oen follows tag bit 0
    for (int i = 0; i < N; i++)
      for (int t = 0; t < T; t++) begin
        step(1'b1, 1'b0, logic'(t % 2), i, t);
        chk("R5 hit_en", int'(hit_en), 1);
        chk("R5 hit", int'(hit), (ref_val[i] && ref_tag[i] == t) ? 1 : 0);
        chk("R6 tag_out_en", int'(tag_out_en), t % 2);
        chk("R6 tag_out", int'(tag_out), (t % 2 == 1) ? ref_tag[i] : 0);
      end

    // R7: unselected writes store nothing
    for (int i = 3; i < N; i += 2) begin
      step(1'b0, 1'b1, 1'b1, i, 9);
      chk("R7 hit_en", int'(hit_en), 0);
      chk("R7 tag_out_en", int'(tag_out_en), 0);
    end
    for (int i = 3; i < N; i += 2) begin
      step(1'b1, 1'b0, 1'b1, i, 9);
      chk("R7 hit after unselected write", int'(hit), 0);
      chk("R7 tag after unselected write", int'(tag_out), 0);
    end

    // R9: second reset invalidates the written sets
    @(negedge clk);
    rst = 1'b1; sel = 1'b0;
    @(posedge clk); #1;
    chk("R1 busy on second reset", int'(busy), 1);
    @(negedge clk);
    rst = 1'b0; sel = 1'b1; wen = 1'b0; idx = 0; tag_in = 3;
    wait_walk(cyc);
    chk("R2 second walk length", cyc, N);
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b0, 1'b1, i, ref_tag[i]);
      chk("R9 hit after reset", int'(hit), 0);
      chk("R9 tag after reset", int'(tag_out), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule